// File: doc/BRIEF.md
# Tiled Surface Address Generator

This block turns a pixel coordinate into a byte offset within a framebuffer surface. The surface may be linear, or built from 4 KiB tiles in one of two shapes. One shape is wide and flat: 512 bytes by 8 rows. The other is narrow and tall: 128 bytes by 32 rows, stored in 16-byte columns. A pixel walker or blitter issues one request per pixel and receives the offset one clock later. It then adds its own surface base address.

For the tiled layouts, an optional bit-6 swizzle can be applied to the offset inside the tile. The swizzle XORs bit 6 with a selected group of bits 9, 10 and 11. This matches the way some memory controllers spread tile rows across channels. The drawing origin is added to the coordinate only in tiled modes. Unsupported settings raise an error flag and force the offset to zero.

Top module: `tile_addr_gen`

## Requirements
- R1: With `tile_mode` = 0 (linear), the offset is (py * pitch + px) * bpp, and `org_x` and `org_y` are ignored.
- R2: With `tile_mode` = 1 (wide tiles), let xb = x * bpp. The in-tile offset is (y mod 8) * 512 + (xb mod 512).
- R3: With `tile_mode` = 2 (tall tiles), let c = xb mod 128 and r = y mod 32. The in-tile offset is (c / 16) * 512 + r * 16 + (c mod 16).
- R4: The tile base is (xb / W) * 4096 + (y / H) * pitch * bpp * H. For wide tiles W = 512 and H = 8. For tall tiles W = 128 and H = 32. The offset is the base plus the swizzled in-tile offset.
- R5: In both tiled modes, x = px + org_x and y = py + org_y are used before any tile math.
- R6: `swz_mode` sets how bit 6 of the in-tile offset is inverted. 0 leaves it unchanged. 1 XORs it with bit 9. 2 XORs it with bits 9 and 10. 3 XORs it with bits 9 and 11. 4 XORs it with bits 9, 10 and 11.
- R7: The request is illegal if `bpp` is not 1, 2 or 4, if `tile_mode` = 3, or if `swz_mode` > 4. An illegal request gives `out_err` = 1 and `out_offset` = 0. A legal request gives `out_err` = 0.
- R8: A request with `in_valid` high is answered exactly one clock later with `out_valid` high for one cycle. Back-to-back requests are answered on consecutive cycles.
- R9: While reset is active, `out_valid`, `out_err` and `out_offset` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| px | input | CW | Pixel x |
| py | input | CW | Pixel y |
| org_x | input | CW | Drawing origin x (tiled modes) |
| org_y | input | CW | Drawing origin y (tiled modes) |
| pitch | input | PW | Surface pitch in pixels |
| bpp | input | 3 | Bytes per pixel (1, 2, 4) |
| tile_mode | input | 2 | 0 linear, 1 wide tiles, 2 tall tiles |
| swz_mode | input | 3 | Bit-6 swizzle select, 0 to 4 |
| out_valid | output | 1 | Result strobe |
| out_offset | output | OW | Byte offset |
| out_err | output | 1 | Illegal-request flag |

## Verification
The output register can present one result in the same cycle that it captures the next request. An illegal request next to a legal one could therefore leak its error or its zero offset into its neighbour. The bench provokes this with back-to-back requests: legal then illegal, then illegal then legal. It checks each cycle's offset and flag against the request issued one clock earlier. It also confirms that `out_valid` drops on the cycle after the last request.

// File: rtl/tile_addr_gen.sv
module tile_addr_gen #(
  parameter int CW = 16,
  parameter int PW = 16,
  parameter int OW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [CW-1:0] px,
  input  logic [CW-1:0] py,
  input  logic [CW-1:0] org_x,
  input  logic [CW-1:0] org_y,
  input  logic [PW-1:0] pitch,
  input  logic [2:0]    bpp,
  input  logic [1:0]    tile_mode,
  input  logic [2:0]    swz_mode,
  output logic          out_valid,
  output logic [OW-1:0] out_offset,
  output logic          out_err
);
  localparam logic [1:0] MODE_LIN  = 2'd0;
  localparam logic [1:0] MODE_WIDE = 2'd1;
  localparam logic [1:0] MODE_TALL = 2'd2;

  logic [1:0]    sh;
  logic          bad;
  logic [OW-1:0] tx, ty, xb, pstride, lin, base, sum;
  logic [11:0]   tin, sw;
  logic          flip;

  always_comb begin
    case (bpp)
      3'd1:    sh = 2'd0;
      3'd2:    sh = 2'd1;
      default: sh = 2'd2;
    endcase
  end

  assign bad = !(bpp == 3'd1 || bpp == 3'd2 || bpp == 3'd4) ||
               (tile_mode == 2'd3) || (swz_mode > 3'd4);

  assign tx      = OW'(px) + OW'(org_x);
  assign ty      = OW'(py) + OW'(org_y);
  assign xb      = tx << sh;
  assign pstride = OW'(pitch) << sh;
  assign lin     = (OW'(py) * OW'(pitch) + OW'(px)) << sh;

  assign tin = (tile_mode == MODE_WIDE) ? {ty[2:0], xb[8:0]}
                                        : {xb[6:4], ty[4:0], xb[3:0]};

  always_comb begin
    case (swz_mode)
      3'd1:    flip = tin[9];
      3'd2:    flip = tin[9] ^ tin[10];
      3'd3:    flip = tin[9] ^ tin[11];
      3'd4:    flip = tin[9] ^ tin[10] ^ tin[11];
      default: flip = 1'b0;
    endcase
  end

  assign sw = tin ^ {5'b0, flip, 6'b0};

  assign base = (tile_mode == MODE_WIDE)
              ? (((xb >> 9) << 12) + (ty >> 3) * (pstride << 3))
              : (((xb >> 7) << 12) + (ty >> 5) * (pstride << 5));

  assign sum = (tile_mode == MODE_LIN) ? lin : base + OW'(sw);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_offset <= '0;
      out_err    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_offset <= bad ? '0 : sum;
        out_err    <= bad;
      end
    end
  end
endmodule

module tile_addr_gen_chk #(
  parameter int OW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [2:0]    bpp,
  input logic [1:0]    tile_mode,
  input logic [2:0]    swz_mode,
  input logic          out_valid,
  input logic [OW-1:0] out_offset,
  input logic          out_err
);
  AST_RESP_NEXT: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R8
  AST_NO_EXTRA: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R8
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_err) |-> (out_offset == '0)); // R7
  AST_BAD_TILE: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && tile_mode == 2'd3) |=> out_err); // R7
  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && bpp == 3'd4 && tile_mode != 2'd3 && swz_mode <= 3'd4) |=> (!out_err && out_offset[1:0] == 2'b00)); // R4
  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (!out_valid && !out_err)); // R9
endmodule

bind tile_addr_gen tile_addr_gen_chk #(.OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .bpp(bpp),
  .tile_mode(tile_mode), .swz_mode(swz_mode), .out_valid(out_valid),
  .out_offset(out_offset), .out_err(out_err)
);

// File: tb/tile_addr_gen_tb.sv
module tile_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] px = '0, py = '0, org_x = '0, org_y = '0, pitch = '0;
  logic [2:0]  bpp = 3'd1;
  logic [1:0]  tile_mode = '0;
  logic [2:0]  swz_mode = '0;
  logic        out_valid;
  logic [31:0] out_offset;
  logic        out_err;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  tile_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .px(px), .py(py),
    .org_x(org_x), .org_y(org_y), .pitch(pitch), .bpp(bpp),
    .tile_mode(tile_mode), .swz_mode(swz_mode), .out_valid(out_valid),
    .out_offset(out_offset), .out_err(out_err)
  );

  typedef struct packed {
    logic [1:0]  tm;
    logic [2:0]  sz;
    logic [2:0]  bp;
    logic [15:0] x, y, ox, oy, pt;
    logic [31:0] ex;
    logic        er;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VT [NV] = '{
    '{2'd0, 3'd0, 3'd4, 16'd10, 16'd3, 16'd5, 16'd7, 16'd100, 32'd1240, 1'b0},
    '{2'd1, 3'd0, 3'd2, 16'd200, 16'd13, 16'd0, 16'd0, 16'd1024, 32'd19344, 1'b0}, // R4 row stride
    '{2'd1, 3'd0, 3'd4, 16'd300, 16'd2, 16'd0, 16'd0, 16'd512, 32'd9392, 1'b0},    // R4 column tile
    '{2'd2, 3'd0, 3'd1, 16'd21, 16'd37, 16'd0, 16'd0, 16'd256, 32'd8789, 1'b0},
    '{2'd1, 3'd0, 3'd4, 16'd4, 16'd1, 16'd60, 16'd6, 16'd128, 32'd3840, 1'b0},
    '{2'd1, 3'd1, 3'd1, 16'd0, 16'd1, 16'd0, 16'd0, 16'd64, 32'd576, 1'b0},
    '{2'd1, 3'd2, 3'd1, 16'd0, 16'd3, 16'd0, 16'd0, 16'd64, 32'd1536, 1'b0},
    '{2'd1, 3'd2, 3'd1, 16'd0, 16'd2, 16'd0, 16'd0, 16'd64, 32'd1088, 1'b0},
    '{2'd1, 3'd3, 3'd1, 16'd0, 16'd5, 16'd0, 16'd0, 16'd64, 32'd2560, 1'b0},
    '{2'd1, 3'd4, 3'd1, 16'd0, 16'd7, 16'd0, 16'd0, 16'd64, 32'd3648, 1'b0},
    '{2'd1, 3'd4, 3'd1, 16'd0, 16'd6, 16'd0, 16'd0, 16'd64, 32'd3072, 1'b0},
    '{2'd2, 3'd1, 3'd1, 16'd64, 16'd0, 16'd0, 16'd0, 16'd64, 32'd2048, 1'b0},
    '{2'd2, 3'd3, 3'd1, 16'd64, 16'd0, 16'd0, 16'd0, 16'd64, 32'd2112, 1'b0},
    '{2'd1, 3'd0, 3'd3, 16'd5, 16'd5, 16'd0, 16'd0, 16'd64, 32'd0, 1'b1},
    '{2'd3, 3'd0, 3'd4, 16'd5, 16'd5, 16'd0, 16'd0, 16'd64, 32'd0, 1'b1},
    '{2'd1, 3'd5, 3'd4, 16'd5, 16'd5, 16'd0, 16'd0, 16'd64, 32'd0, 1'b1},
    '{2'd2, 3'd0, 3'd2, 16'd10, 16'd0, 16'd3, 16'd40, 16'd16, 32'd1674, 1'b0},
    '{2'd0, 3'd7, 3'd1, 16'd1, 16'd1, 16'd0, 16'd0, 16'd10, 32'd0, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_off(input int tm, input int sz, input int bp,
      input longint x0, input longint y0, input longint ox, input longint oy, input longint pt);
    longint x, y, xb, it, w, h, col, row, r;
    int b9, b10, b11, f;
    if (tm == 0) return 32'((y0 * pt + x0) * bp);
    x = x0 + ox; y = y0 + oy; xb = x * bp;
    if (tm == 1) begin
      w = 512; h = 8; col = xb % 512; row = y % 8; it = row * 512 + col;
    end else begin
      w = 128; h = 32; col = xb % 128; row = y % 32;
      it = (col / 16) * 512 + row * 16 + col % 16;
    end
    b9 = int'((it / 512) % 2); b10 = int'((it / 1024) % 2); b11 = int'((it / 2048) % 2);
    case (sz)
      1: f = b9;
      2: f = b9 ^ b10;
      3: f = b9 ^ b11;
      4: f = b9 ^ b10 ^ b11;
      default: f = 0;
    endcase
    if (f != 0) it = ((it / 64) % 2 == 1) ? it - 64 : it + 64;
    r = (xb / w) * 4096 + (y / h) * pt * bp * h + it;
    return 32'(r);
  endfunction

  task automatic drive(input vec_t v);
    tile_mode = v.tm; swz_mode = v.sz; bpp = v.bp;
    px = v.x; py = v.y; org_x = v.ox; org_y = v.oy; pitch = v.pt;
    in_valid = 1'b1;
  endtask

  function automatic string tag(input vec_t v);
    if (v.er) return "R7";
    if (v.sz != 0) return "R6";
    if (v.tm != 0 && (v.ox != 0 || v.oy != 0)) return "R5";
    if (v.tm == 0) return "R1";
    if (v.tm == 1) return "R2";
    return "R3";
  endfunction

  initial begin
    #2000000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    vec_t v, w;
    repeat (3) @(negedge clk);
    check("R9 valid", {31'b0, out_valid}, 32'd0);
    check("R9 err", {31'b0, out_err}, 32'd0);
    check("R9 offset", out_offset, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk); drive(VT[i]);
      @(negedge clk); in_valid = 1'b0;
      check(tag(VT[i]), out_offset, VT[i].ex);
      check({tag(VT[i]), " err"}, {31'b0, out_err}, {31'b0, VT[i].er});
      check("R8 valid", {31'b0, out_valid}, 32'd1);
    end
    @(negedge clk);
    check("R8 single pulse", {31'b0, out_valid}, 32'd0);

    // R8: back-to-back legal, illegal, legal
    @(negedge clk); drive(VT[1]);
    @(negedge clk); drive(VT[14]);
    check("R8 b2b first", out_offset, VT[1].ex);
    check("R8 b2b first err", {31'b0, out_err}, 32'd0);
    @(negedge clk); drive(VT[3]);
    check("R7 b2b illegal", out_offset, 32'd0);
    check("R7 b2b illegal err", {31'b0, out_err}, 32'd1);
    @(negedge clk); in_valid = 1'b0;
    check("R8 b2b recover", out_offset, VT[3].ex);
    check("R8 b2b recover err", {31'b0, out_err}, 32'd0);
    check("R8 b2b valid", {31'b0, out_valid}, 32'd1);
    @(negedge clk);
    check("R8 b2b end", {31'b0, out_valid}, 32'd0);

    // R4 and R2/R3/R6 sweep against the bench reference
    for (int tm = 0; tm < 3; tm++)
      for (int sz = 0; sz < 5; sz++)
        for (int bi = 0; bi < 3; bi++)
          for (int k = 0; k < 12; k++) begin
            w.tm = 2'(tm); w.sz = 3'(sz); w.bp = 3'(1 << bi);
            w.x = 16'($urandom_range(0, 4095)); w.y = 16'($urandom_range(0, 4095));
            w.ox = 16'($urandom_range(0, 255)); w.oy = 16'($urandom_range(0, 255));
            w.pt = 16'($urandom_range(1, 4096));
            w.ex = ref_off(tm, sz, 1 << bi, w.x, w.y, w.ox, w.oy, w.pt); w.er = 1'b0;
            @(negedge clk); drive(w);
            @(negedge clk); in_valid = 1'b0;
            check(tm == 0 ? "R1 sweep" : "R4 sweep", out_offset, w.ex);
          end

    // R9: reset mid-stream clears outputs
    @(negedge clk); v = VT[2]; drive(v); rst_n = 1'b0;
    @(negedge clk); in_valid = 1'b0;
    check("R9 mid reset valid", {31'b0, out_valid}, 32'd0);
    check("R9 mid reset offset", out_offset, 32'd0);
    rst_n = 1'b1;

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule